// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Truncating Normalisation

This block multiplies two 32-bit single-precision words. Each word holds a sign in bit 31, an 8-bit biased exponent in bits 30..23 and a 23-bit fraction in bits 22..0. The result sign is the exclusive-or of the operand signs. The significands are the fractions with an implicit leading one restored; they are multiplied into a 48-bit product. A single one-position select on the top product bit normalises that product. The exponents are added and the bias is removed by adding its two's complement.

No rounding is applied, and the datapath has no special-value handling. Exponent fields of 0 and 255 are treated like any other value, and the exponent result wraps modulo 256. The datapath can be built purely combinational or with one output register that has a clock enable. The register is selected by a parameter, and the default is registered. The block suits datapaths that accept truncated products and only ever present normal operands.

Top module: `fp32_trunc_mul`

## Requirements
- R1: Result bit 31 equals the XOR of operand bit 31 of `op_a` and `op_b`.
- R2: When product bit 47 is 0, the result exponent field (bits 30..23) equals (EA + EB − 127) mod 256, where EA and EB are the operand exponent fields.
- R3: Significands are {1, fraction} (24 bits). When their 48-bit product has bit 47 set, the result fraction is product bits 46..24 and the exponent is (EA + EB − 126) mod 256.
- R4: When product bit 47 is 0, the result fraction is product bits 45..23.
- R5: Product bits below the selected 23-bit window are discarded with no rounding (e.g. 0x3FC00001 × 0x3FC00001 gives 0x40100001).
- R6: The result is packed as sign in bit 31, exponent in bits 30..23 and fraction in bits 22..0. For example, 0xC18ECCCD × 0x41491EB8 gives 0xC3605FDF.
- R7: Exponent fields 0 and 255 are ordinary values: 0x00000000 × 0x00000000 gives 0x40800000, and 0x7F800000 × 0x7F800000 gives 0x3F800000.
- R8: In the registered variant, `result` takes the product of the operands present at a rising edge where `en` is 1. At an edge where `en` is 0, `result` holds its value.
- R9: While `rst_n` is 0, `result` is 0 in the registered variant, and it stays 0 until the first enabled edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output register |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| result | output | 32 | Product word |

## Verification
The assertions check three things on every enabled cycle: the sign relation, that the exponent field lands within one step of EA + EB − 127, and that an operand of exactly 1.0 passes the other operand through unchanged. On cycles with `en` low they check that the output holds. Only the bench scenarios show the exact fraction window chosen by the normalisation select and the bits that truncation discards. The same holds for the exponent wrap at fields 0 and 255 and the reset value. For these the bench compares every cycle against a behavioural model and adds directed corner vectors with fixed expected words.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned FPM_EXP_W  = 8;
  localparam int unsigned FPM_FRAC_W = 23;
  localparam int unsigned FPM_BIAS   = 127;
  localparam int unsigned FPM_WORD_W = 1 + FPM_EXP_W + FPM_FRAC_W;

  typedef enum logic {
    NORM_KEEP  = 1'b0,
    NORM_SHIFT = 1'b1
  } norm_sel_e;
endpackage

// File: rtl/fpm_exp_add.sv
module fpm_exp_add #(
  parameter int unsigned EXP_W = fpm_pkg::FPM_EXP_W,
  parameter int unsigned BIAS  = fpm_pkg::FPM_BIAS
) (
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic             bump,
  output logic [EXP_W-1:0] exp_out
);
  localparam int unsigned SUM_W = EXP_W + 2;
  localparam logic [SUM_W-1:0] NEG_BIAS = ~SUM_W'(BIAS) + SUM_W'(1);

  logic [SUM_W-1:0] sum_w;
  logic [1:0]       unused_top;

  always_comb begin
    sum_w = {2'b00, exp_a} + {2'b00, exp_b} + NEG_BIAS + SUM_W'(bump);
  end

  assign exp_out    = sum_w[EXP_W-1:0];
  assign unused_top = sum_w[SUM_W-1:EXP_W];
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int unsigned FRAC_W = fpm_pkg::FPM_FRAC_W
) (
  input  logic [FRAC_W-1:0]       frac_a,
  input  logic [FRAC_W-1:0]       frac_b,
  output logic [2*(FRAC_W+1)-1:0] prod
);
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * SIG_W;

  logic [SIG_W-1:0] sig_a, sig_b;

  assign sig_a = {1'b1, frac_a};
  assign sig_b = {1'b1, frac_b};

  always_comb begin
    prod = PROD_W'(sig_a) * PROD_W'(sig_b);
  end
endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
  parameter int unsigned FRAC_W = fpm_pkg::FPM_FRAC_W
) (
  input  logic [2*(FRAC_W+1)-1:0] prod,
  output logic [FRAC_W-1:0]       frac_out,
  output logic                    bump
);
  import fpm_pkg::*;
  localparam int unsigned PROD_W = 2 * (FRAC_W + 1);
  localparam int unsigned TOP    = PROD_W - 1;

  norm_sel_e        sel;
  logic [FRAC_W-1:0] unused_low;

  assign sel = norm_sel_e'(prod[TOP]);

  always_comb begin
    unique case (sel)
      NORM_SHIFT: frac_out = prod[TOP-1 -: FRAC_W];
      default:    frac_out = prod[TOP-2 -: FRAC_W];
    endcase
  end

  assign bump       = (sel == NORM_SHIFT);
  assign unused_low = prod[FRAC_W-1:0];
endmodule

// File: rtl/fp32_trunc_mul.sv
module fp32_trunc_mul #(
  parameter int unsigned EXP_W   = fpm_pkg::FPM_EXP_W,
  parameter int unsigned FRAC_W  = fpm_pkg::FPM_FRAC_W,
  parameter int unsigned BIAS    = fpm_pkg::FPM_BIAS,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic [EXP_W+FRAC_W:0]     result
);
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned SIGN_B = WORD_W - 1;
  localparam int unsigned PROD_W = 2 * (FRAC_W + 1);

  logic [PROD_W-1:0] prod;
  logic [FRAC_W-1:0] frac_n;
  logic              bump;
  logic [EXP_W-1:0]  exp_n;
  logic              sign_n;
  logic [WORD_W-1:0] word_n;

  assign sign_n = op_a[SIGN_B] ^ op_b[SIGN_B];

  fpm_sig_mul #(.FRAC_W(FRAC_W)) u_mul (
    .frac_a (op_a[FRAC_W-1:0]),
    .frac_b (op_b[FRAC_W-1:0]),
    .prod   (prod)
  );

  fpm_norm #(.FRAC_W(FRAC_W)) u_norm (
    .prod     (prod),
    .frac_out (frac_n),
    .bump     (bump)
  );

  fpm_exp_add #(.EXP_W(EXP_W), .BIAS(BIAS)) u_exp (
    .exp_a   (op_a[SIGN_B-1:FRAC_W]),
    .exp_b   (op_b[SIGN_B-1:FRAC_W]),
    .bump    (bump),
    .exp_out (exp_n)
  );

  assign word_n = {sign_n, exp_n, frac_n};

  generate
    if (OUT_REG) begin : g_reg
      logic [WORD_W-1:0] res_q, res_d;

      always_comb begin
        res_d = res_q;
        if (en) res_d = word_n;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
      end

      assign result = res_q;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n ^ en;
      assign result     = word_n;
    end
  endgenerate
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter int unsigned BIAS    = 127,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [EXP_W+FRAC_W:0] result
);
  localparam int unsigned SB = EXP_W + FRAC_W;
  localparam logic [SB:0] ONE_W = {1'b0, EXP_W'(BIAS), {FRAC_W{1'b0}}};

  generate
    if (OUT_REG) begin : g_chk
      // R1: sign is the XOR of operand signs
      p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> result[SB] == ($past(op_a[SB]) ^ $past(op_b[SB])));

      // R2 / R3: exponent lands at EA+EB-bias or one above it
      p_exp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> EXP_W'(result[SB-1:FRAC_W] - $past(op_a[SB-1:FRAC_W])
                      - $past(op_b[SB-1:FRAC_W]) + EXP_W'(BIAS)) <= EXP_W'(1));

      // R4 / R6: multiplying by exactly 1.0 returns the other operand
      p_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_b == ONE_W) |=> result == $past(op_a));

      // R8: register holds while the enable is low
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result));
    end
  endgenerate
endmodule

bind fp32_trunc_mul fpm_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b), .result(result)
);

// File: tb/sim_fp32_trunc_mul.sv
module sim_fp32_trunc_mul;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] op_a, op_b;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";
  logic [31:0] mdl_q;
  bit cmp_on = 1'b0;

  fp32_trunc_mul u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint unsigned sa, sb, p;
    int e;
    logic [22:0] f;
    sa = longint'(a[22:0]) + (64'd1 << 23);
    sb = longint'(b[22:0]) + (64'd1 << 23);
    p  = sa * sb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p >= (64'd1 << 47)) begin
      f = 23'((p / (64'd1 << 24)) % (64'd1 << 23));
      e = e + 1;
    end else begin
      f = 23'((p / (64'd1 << 23)) % (64'd1 << 23));
    end
    return {a[31] ^ b[31], 8'(e & 255), f};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl_q <= '0;
    else if (en) mdl_q <= ref_mul(op_a, op_b);
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, got, want);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) check(cur_req, result, mdl_q);
  end

  task automatic apply(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] want);
    @(negedge clk);
    cur_req = req;
    en = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    #1;
    check(req, result, want);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; en = 1'b0; op_a = 32'h4049_0FDB; op_b = 32'h4049_0FDB;
    repeat (3) @(negedge clk);
    check("R9", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", result, 32'h0);
    cmp_on = 1'b1;

    apply("R6", 32'hC18E_CCCD, 32'h4149_1EB8, 32'hC360_5FDF);
    check("R1", {31'h0, result[31]}, 32'h1);
    check("R2", {24'h0, result[30:23]}, 32'h86);
    apply("R4", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000);
    apply("R3", 32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000);
    apply("R3", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFE);
    apply("R5", 32'h3FC0_0001, 32'h3FC0_0001, 32'h4010_0001);
    apply("R5", 32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002);
    apply("R7", 32'h0000_0000, 32'h0000_0000, 32'h4080_0000);
    apply("R7", 32'h7F80_0000, 32'h7F80_0000, 32'h3F80_0000);
    apply("R1", 32'hBF80_0000, 32'h3F80_0000, 32'hBF80_0000);
    apply("R1", 32'hBF80_0000, 32'hBF80_0000, 32'h3F80_0000);
    apply("R2", 32'h4100_0000, 32'h4080_0000, 32'h4200_0000);

    @(negedge clk);
    cur_req = "R8";
    en = 1'b0; op_a = 32'h4040_0000; op_b = 32'hC0A0_0000;
    repeat (2) @(negedge clk);
    #1;
    check("R8", result, 32'h4200_0000);
    apply("R8", 32'h4040_0000, 32'hC0A0_0000, 32'hC170_0000);

    cur_req = "R6";
    lf = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op_a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op_b = {lf[31:24] ^ lf[7:0], lf[23:0]};
      en = lf[3] | lf[9];
    end
    @(negedge clk);
    @(negedge clk);
    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule